// File: doc/BRIEF.md
# Pixel Blend and Raster ALU

This block takes one source pixel and one destination pixel and produces one result pixel. Each pixel has four 8-bit channels, packed as alpha in bits 31:24 and the three colour channels in bits 23:16, 15:8 and 7:0. The three colour channels share one path and alpha has its own path. Each path has a 3-bit operation code and two 4-bit factor selectors. The source term is the source channel scaled by the source factor. The destination term is the destination channel scaled by the destination factor. The operation then adds, subtracts, takes the minimum or maximum of the two terms, or applies a bitwise raster operation to the raw channels. A separate constant pixel input supplies the constant colour and constant alpha factors.

Pixels enter and leave through valid/ready handshakes. The 32-bit control word and the constant pixel are sampled together with each source/destination pair, so every pixel can carry its own operation. The block is a fixed two-stage pipeline. Each stage is a slot with a two-state controller: SLOT_EMPTY and SLOT_FULL. The controller takes four transitions. "fill" goes from SLOT_EMPTY to SLOT_FULL when a pixel is taken. "drain" goes from SLOT_FULL to SLOT_EMPTY when a pixel leaves and none arrives. "hold" keeps SLOT_FULL when the slot is stalled. "pass" keeps SLOT_FULL when one pixel leaves and the next arrives on the same edge. Stage one forms the two scaled terms of every channel. Stage two combines them and holds the result at the output.

Top module: `pix_blend_alu`

## Requirements
- R1: With operation 0 (add), a result channel is the source term plus the destination term, saturated at 255.
- R2: Operation 1 gives the source term minus the destination term. Operation 2 gives the destination term minus the source term. Both results clamp at 0.
- R3: Operation 3 gives the minimum of the two terms. Operation 4 gives their maximum.
- R4: Operation 5 applies a bitwise operation to the raw source s and raw destination d. The path's destination-factor field selects the operation: 0 gives 0, 1 gives s, 2 gives d, 3 gives all ones, 4 gives ~s, 5 gives ~d, 6 gives s&~d, 7 gives s|~d, 8 gives s&d, 9 gives s|d, 10 gives ~(s&d), 11 gives ~(s|d), 12 gives s^d, 13 gives ~(s^d), 14 gives ~s&d and 15 gives ~s|d.
- R5: Colour factor codes select 0 zero, 1 one, 2 source colour, 3 one minus source colour, 4 destination colour, 5 one minus destination colour, 6 source alpha, 7 one minus source alpha, 8 destination alpha, 9 one minus destination alpha, 10 constant colour, 11 one minus constant colour, 12 constant alpha and 13 one minus constant alpha. Code 14 selects min(source alpha, 255 − destination alpha). Here "one" is 255, "colour" means the same channel of the same pixel, and the constants come from the constant pixel input.
- R6: Alpha factor codes select 0 zero, 1 one, 2 source alpha, 3 one minus source alpha, 4 destination alpha, 5 one minus destination alpha, 6 constant alpha and 7 one minus constant alpha. Alpha codes 8 to 15 and colour code 15 select zero.
- R7: Each scaled term is (channel·factor + 127) / 255, with the division truncating.
- R8: Operation codes 6 and 7 pass the destination channel through unchanged.
- R9: The control word fields are as follows: colour operation in bits 22:20, colour source factor in bits 19:16, colour destination factor in bits 15:12, alpha operation in bits 10:8, alpha source factor in bits 7:4 and alpha destination factor in bits 3:0.
- R10: A pixel accepted at a clock edge appears on out_px, with out_valid high, after the second following edge when out_ready stays high. No more than two pixels are ever inside the block.
- R11: While out_valid is high and out_ready is low, out_valid and out_px hold their values. in_ready is low only in that condition. Pixels leave in the order they entered, and none is lost.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel pair is offered |
| in_ready | output | 1 | Block can take the offered pair |
| ctrl_word | input | 32 | Per-pixel operation and factor selection |
| src_px | input | 32 | Source pixel |
| dst_px | input | 32 | Destination pixel |
| const_px | input | 32 | Constant colour and alpha for constant factors |
| out_valid | output | 1 | Result pixel is available |
| out_ready | input | 1 | Consumer takes the result |
| out_px | output | 32 | Result pixel |

## Verification
The assertions watch the flow control on every cycle. They check that a stalled output keeps its value and its valid flag. They check that in_ready drops only when the output is stalled. A count of pixels in flight is kept and checked against the two-slot capacity, and out_valid must never be high while that count is zero. The arithmetic can only be shown by the bench's scenarios: saturation and clamping, the rounding of scaled terms, each factor table, the raster operations and the pass-through codes. The same holds for the exact two-cycle latency and for the ordering of pixels through a long stall, both of which the bench compares with a model written from the requirements.

// File: rtl/pba_pkg.sv
package pba_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_t;

    localparam int OP_W     = 3;
    localparam int CODE_W   = 4;
    localparam int COP_LSB  = 20;
    localparam int CSRC_LSB = 16;
    localparam int CDST_LSB = 12;
    localparam int AOP_LSB  = 8;
    localparam int ASRC_LSB = 4;
    localparam int ADST_LSB = 0;

    localparam logic [OP_W-1:0] OP_ADD   = 3'd0;
    localparam logic [OP_W-1:0] OP_SUB   = 3'd1;
    localparam logic [OP_W-1:0] OP_RSUB  = 3'd2;
    localparam logic [OP_W-1:0] OP_MIN   = 3'd3;
    localparam logic [OP_W-1:0] OP_MAX   = 3'd4;
    localparam logic [OP_W-1:0] OP_LOGIC = 3'd5;

endpackage

// File: rtl/pba_slot_ctl.sv
module pba_slot_ctl
    import pba_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic full
);

    slot_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (take) state_d = SLOT_FULL;
            SLOT_FULL:  if (give && !take) state_d = SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        full = (state_q == SLOT_FULL);
    end

endmodule

// File: rtl/pba_factor_lane.sv
module pba_factor_lane
    import pba_pkg::*;
#(
    parameter int CH_W     = 8,
    parameter bit IS_ALPHA = 1'b0
) (
    input  logic [CH_W-1:0]   s_ch,
    input  logic [CH_W-1:0]   d_ch,
    input  logic [CH_W-1:0]   c_ch,
    input  logic [CH_W-1:0]   s_a,
    input  logic [CH_W-1:0]   d_a,
    input  logic [CH_W-1:0]   c_a,
    input  logic [CODE_W-1:0] src_code,
    input  logic [CODE_W-1:0] dst_code,
    output logic [CH_W-1:0]   s_term,
    output logic [CH_W-1:0]   d_term
);

    localparam logic [CH_W-1:0] ONE  = {CH_W{1'b1}};
    localparam int              PW   = 2 * CH_W + 1;
    localparam logic [PW-1:0]   MAXV = PW'(ONE);
    localparam logic [PW-1:0]   HALF = PW'(ONE) >> 1;

    logic [CH_W-1:0] f_src, f_dst;

    function automatic logic [CH_W-1:0] color_fac(
        input logic [CODE_W-1:0] code,
        input logic [CH_W-1:0] s, d, c, sa, da, ca
    );
        logic [CH_W-1:0] inv_da;
        inv_da = ONE - da;
        case (code)
            4'd1:    return ONE;
            4'd2:    return s;
            4'd3:    return ONE - s;
            4'd4:    return d;
            4'd5:    return ONE - d;
            4'd6:    return sa;
            4'd7:    return ONE - sa;
            4'd8:    return da;
            4'd9:    return inv_da;
            4'd10:   return c;
            4'd11:   return ONE - c;
            4'd12:   return ca;
            4'd13:   return ONE - ca;
            4'd14:   return (sa < inv_da) ? sa : inv_da;
            default: return '0;
        endcase
    endfunction

    function automatic logic [CH_W-1:0] alpha_fac(
        input logic [CODE_W-1:0] code,
        input logic [CH_W-1:0] sa, da, ca
    );
        case (code)
            4'd1:    return ONE;
            4'd2:    return sa;
            4'd3:    return ONE - sa;
            4'd4:    return da;
            4'd5:    return ONE - da;
            4'd6:    return ca;
            4'd7:    return ONE - ca;
            default: return '0;
        endcase
    endfunction

    generate
        if (IS_ALPHA) begin : g_alpha
            logic c_unused;
            assign c_unused = ^c_ch;
            always_comb begin
                f_src = alpha_fac(src_code, s_a, d_a, c_a);
                f_dst = alpha_fac(dst_code, s_a, d_a, c_a);
            end
        end else begin : g_color
            always_comb begin
                f_src = color_fac(src_code, s_ch, d_ch, c_ch, s_a, d_a, c_a);
                f_dst = color_fac(dst_code, s_ch, d_ch, c_ch, s_a, d_a, c_a);
            end
        end
    endgenerate

    logic [PW-1:0] ps_full, pd_full;

    always_comb begin
        ps_full = (PW'(s_ch) * PW'(f_src) + HALF) / MAXV;
        pd_full = (PW'(d_ch) * PW'(f_dst) + HALF) / MAXV;
        s_term  = ps_full[CH_W-1:0];
        d_term  = pd_full[CH_W-1:0];
    end

endmodule

// File: rtl/pba_combine_lane.sv
module pba_combine_lane
    import pba_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic [OP_W-1:0]   op,
    input  logic [CODE_W-1:0] sel,
    input  logic [CH_W-1:0]   s,
    input  logic [CH_W-1:0]   d,
    input  logic [CH_W-1:0]   ps,
    input  logic [CH_W-1:0]   pd,
    output logic [CH_W-1:0]   res
);

    logic [CH_W:0]   sum;
    logic [CH_W-1:0] rop;

    always_comb begin
        case (sel)
            4'd0:    rop = '0;
            4'd1:    rop = s;
            4'd2:    rop = d;
            4'd3:    rop = '1;
            4'd4:    rop = ~s;
            4'd5:    rop = ~d;
            4'd6:    rop = s & ~d;
            4'd7:    rop = s | ~d;
            4'd8:    rop = s & d;
            4'd9:    rop = s | d;
            4'd10:   rop = ~(s & d);
            4'd11:   rop = ~(s | d);
            4'd12:   rop = s ^ d;
            4'd13:   rop = ~(s ^ d);
            4'd14:   rop = ~s & d;
            default: rop = ~s | d;
        endcase
    end

    always_comb begin
        sum = {1'b0, ps} + {1'b0, pd};
        case (op)
            OP_ADD:   res = sum[CH_W] ? '1 : sum[CH_W-1:0];
            OP_SUB:   res = (ps > pd) ? ps - pd : '0;
            OP_RSUB:  res = (pd > ps) ? pd - ps : '0;
            OP_MIN:   res = (ps < pd) ? ps : pd;
            OP_MAX:   res = (ps > pd) ? ps : pd;
            OP_LOGIC: res = rop;
            default:  res = d;
        endcase
    end

endmodule

// File: rtl/pix_blend_alu.sv
module pix_blend_alu
    import pba_pkg::*;
#(
    parameter int CH_W = 8,
    parameter int NCH  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [31:0]         ctrl_word,
    input  logic [CH_W*NCH-1:0] src_px,
    input  logic [CH_W*NCH-1:0] dst_px,
    input  logic [CH_W*NCH-1:0] const_px,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [CH_W*NCH-1:0] out_px
);

    localparam int AL = NCH - 1;

    logic s1_full, s2_full, in_fire, s1_adv, out_fire;
    logic ctrl_unused;

    assign ctrl_unused = ^{ctrl_word[31:23], ctrl_word[11]};

    assign s1_adv    = s1_full && (!s2_full || out_ready);
    assign in_ready  = !s1_full || s1_adv;
    assign in_fire   = in_valid && in_ready;
    assign out_valid = s2_full;
    assign out_fire  = s2_full && out_ready;

    pba_slot_ctl u_slot1 (
        .clk  (clk),
        .rst_n(rst_n),
        .take (in_fire),
        .give (s1_adv),
        .full (s1_full)
    );

    pba_slot_ctl u_slot2 (
        .clk  (clk),
        .rst_n(rst_n),
        .take (s1_adv),
        .give (out_fire),
        .full (s2_full)
    );

    logic [CH_W-1:0] s_a, d_a, c_a;
    assign s_a = src_px[AL*CH_W +: CH_W];
    assign d_a = dst_px[AL*CH_W +: CH_W];
    assign c_a = const_px[AL*CH_W +: CH_W];

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_lane
            localparam bit IS_A = (i == AL);
            localparam int OPL  = IS_A ? AOP_LSB  : COP_LSB;
            localparam int SRL  = IS_A ? ASRC_LSB : CSRC_LSB;
            localparam int DSL  = IS_A ? ADST_LSB : CDST_LSB;

            logic [CH_W-1:0]   ps_c, pd_c, res_c;
            logic [CH_W-1:0]   s_q, d_q, ps_q, pd_q, out_q;
            logic [OP_W-1:0]   op_q;
            logic [CODE_W-1:0] sel_q;

            pba_factor_lane #(.CH_W(CH_W), .IS_ALPHA(IS_A)) u_fac (
                .s_ch    (src_px[i*CH_W +: CH_W]),
                .d_ch    (dst_px[i*CH_W +: CH_W]),
                .c_ch    (const_px[i*CH_W +: CH_W]),
                .s_a     (s_a),
                .d_a     (d_a),
                .c_a     (c_a),
                .src_code(ctrl_word[SRL +: CODE_W]),
                .dst_code(ctrl_word[DSL +: CODE_W]),
                .s_term  (ps_c),
                .d_term  (pd_c)
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s_q   <= '0;
                    d_q   <= '0;
                    ps_q  <= '0;
                    pd_q  <= '0;
                    op_q  <= '0;
                    sel_q <= '0;
                end else if (in_fire) begin
                    s_q   <= src_px[i*CH_W +: CH_W];
                    d_q   <= dst_px[i*CH_W +: CH_W];
                    ps_q  <= ps_c;
                    pd_q  <= pd_c;
                    op_q  <= ctrl_word[OPL +: OP_W];
                    sel_q <= ctrl_word[DSL +: CODE_W];
                end
            end

            pba_combine_lane #(.CH_W(CH_W)) u_comb (
                .op (op_q),
                .sel(sel_q),
                .s  (s_q),
                .d  (d_q),
                .ps (ps_q),
                .pd (pd_q),
                .res(res_c)
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      out_q <= '0;
                else if (s1_adv) out_q <= res_c;
            end

            assign out_px[i*CH_W +: CH_W] = out_q;
        end
    endgenerate

endmodule

// File: rtl/pba_checker.sv
module pba_checker #(
    parameter int PIX_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_px
);

    logic [2:0] inflight;
    logic       in_fire, out_fire;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight <= '0;
        else if (in_fire && !out_fire) inflight <= inflight + 3'd1;
        else if (out_fire && !in_fire) inflight <= inflight - 3'd1;
    end

    // R11: a stalled result keeps its flag and its value
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_px)));

    // R11: input back-pressure only comes from a stalled output
    assert_ready_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));

    // R10: never more than two pixels inside
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= 3'd2);

    // R10: a result is only offered for a pixel that went in
    assert_valid_backed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight != 3'd0));

endmodule

bind pix_blend_alu pba_checker u_pba_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_px   (out_px)
);

// File: tb/pix_blend_alu_bench.sv
module pix_blend_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] ctrl_word = '0, src_px = '0, dst_px = '0, const_px = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_px;

    always #10 clk = ~clk;

    pix_blend_alu u_pix_blend_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .ctrl_word(ctrl_word), .src_px(src_px), .dst_px(dst_px), .const_px(const_px),
        .out_valid(out_valid), .out_ready(out_ready), .out_px(out_px)
    );

    int checks = 0, fails = 0, cyc = 0, sent = 0, got = 0;
    int ready_mode = 0, accept_cyc = 0, out_cyc = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    function automatic int mul(input int a, input int b);
        return (a * b + 127) / 255;
    endfunction

    function automatic int cfac(input int code, input int s, d, c, sa, da, ca);
        case (code)
            1: return 255;          2: return s;
            3: return 255 - s;      4: return d;
            5: return 255 - d;      6: return sa;
            7: return 255 - sa;     8: return da;
            9: return 255 - da;     10: return c;
            11: return 255 - c;     12: return ca;
            13: return 255 - ca;
            14: return (sa < 255 - da) ? sa : 255 - da;
            default: return 0;
        endcase
    endfunction

    function automatic int afac(input int code, input int sa, da, ca);
        case (code)
            1: return 255;      2: return sa;
            3: return 255 - sa; 4: return da;
            5: return 255 - da; 6: return ca;
            7: return 255 - ca;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] lop(input int sel, input logic [7:0] s, input logic [7:0] d);
        case (sel)
            0: return 8'h00;     1: return s;
            2: return d;         3: return 8'hFF;
            4: return ~s;        5: return ~d;
            6: return s & ~d;    7: return s | ~d;
            8: return s & d;     9: return s | d;
            10: return ~(s & d); 11: return ~(s | d);
            12: return s ^ d;    13: return ~(s ^ d);
            14: return ~s & d;
            default: return ~s | d;
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [31:0] cw, input logic [31:0] s, d, k);
        logic [31:0] r;
        int sa, da, ca;
        sa = s[31:24]; da = d[31:24]; ca = k[31:24];
        for (int i = 0; i < 4; i++) begin
            int sc, dc, cc, op, fs, fd, ps, pd, v, sel;
            sc = s[i*8 +: 8]; dc = d[i*8 +: 8]; cc = k[i*8 +: 8];
            if (i == 3) begin
                op = cw[10:8]; sel = cw[3:0];
                fs = afac(cw[7:4], sa, da, ca);
                fd = afac(cw[3:0], sa, da, ca);
            end else begin
                op = cw[22:20]; sel = cw[15:12];
                fs = cfac(cw[19:16], sc, dc, cc, sa, da, ca);
                fd = cfac(cw[15:12], sc, dc, cc, sa, da, ca);
            end
            ps = mul(sc, fs); pd = mul(dc, fd);
            case (op)
                0: v = (ps + pd > 255) ? 255 : ps + pd;
                1: v = (ps > pd) ? ps - pd : 0;
                2: v = (pd > ps) ? pd - ps : 0;
                3: v = (ps < pd) ? ps : pd;
                4: v = (ps > pd) ? ps : pd;
                5: v = lop(sel, s[i*8 +: 8], d[i*8 +: 8]);
                default: v = dc;
            endcase
            r[i*8 +: 8] = 8'(v);
        end
        return r;
    endfunction

    function automatic string op_tag(input logic [31:0] cw);
        case (cw[22:20])
            3'd0: return "R1 random add";
            3'd1, 3'd2: return "R2 random subtract";
            3'd3, 3'd4: return "R3 random min/max";
            3'd5: return "R4 random logic";
            default: return "R8 random pass";
        endcase
    endfunction

    task automatic send(input logic [31:0] cw, s, d, k, e, input string t);
        @(negedge clk);
        in_valid = 1'b1; ctrl_word = cw; src_px = s; dst_px = d; const_px = k;
        exp_q.push_back(e); tag_q.push_back(t);
        forever begin
            #5;
            if (in_ready) break;
            @(negedge clk);
        end
        accept_cyc = cyc;
        sent++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (got != sent || exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            case (ready_mode)
                0: out_ready = 1'b1;
                1: out_ready = 1'($urandom_range(0, 1));
                default: out_ready = 1'b0;
            endcase
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (rst_n && out_valid && out_ready) begin
                out_cyc = cyc;
                got++;
                if (exp_q.size() == 0) chk(1'b0, "R11 unexpected output", out_px, 32'h0);
                else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(out_px == e, t, out_px, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        int unused_seed;
        logic [31:0] p;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #5;
        chk(out_valid == 1'b0, "R12 reset out_valid", {31'b0, out_valid}, 32'h0);
        chk(in_ready == 1'b1, "R12 reset in_ready", {31'b0, in_ready}, 32'h1);

        // directed corner cases, expected values worked by hand
        send(32'h000C0060, 32'h64646464, 32'h00000000, 32'h80000000, 32'h32323232, "R7 rounding const alpha");
        send(32'h00011011, 32'hC8C8C8C8, 32'h64646464, 32'h0, 32'hFFFFFFFF, "R1 add saturate");
        send(32'h00011011, 32'h10203040, 32'h01020304, 32'h0, 32'h11223344, "R1 add plain");
        send(32'h00111211, 32'h50108020, 32'h30203030, 32'h0, 32'h00005000, "R2 sub clamp");
        send(32'h00311411, 32'h109020F0, 32'h20304050, 32'h0, 32'h20302050, "R3 min max");
        send(32'h0050C506, 32'hF0FF00AA, 32'h3C0F0F55, 32'h0, 32'hC0F00FFF, "R4 xor and-reverse");
        send(32'h00611711, 32'hFFFFFFFF, 32'h12345678, 32'h0, 32'h12345678, "R8 pass codes 6 7");
        send(32'h000F1091, 32'hFFFFFFFF, 32'h11223344, 32'h0, 32'h11223344, "R6 unused codes zero");
        send(32'h000E0010, 32'hFFFF00C8, 32'h40000000, 32'h0, 32'hFFBF0096, "R5 alpha saturate");
        send(32'h000A5070, 32'hFFFFFFFF, 32'h0000FF00, 32'h408000FF, 32'hBF8000FF, "R9 fields const factors");
        drain();

        // latency through an idle pipe
        send(32'h00011011, 32'h01010101, 32'h01010101, 32'h0, 32'h02020202, "R10 latency data");
        drain();
        chk(out_cyc == accept_cyc + 2, "R10 two-cycle latency", 32'(out_cyc - accept_cyc), 32'd2);

        // long stall with back-pressure
        ready_mode = 2;
        fork
            begin
                for (int n = 0; n < 4; n++)
                    send(32'h00011011, 32'(n * 32'h01010101), 32'h10101010, 32'h0,
                         32'h10101010 + 32'(n * 32'h01010101), "R11 order after stall");
            end
        join_none
        repeat (10) @(negedge clk);
        #5;
        chk(in_ready == 1'b0, "R11 in_ready low when full", {31'b0, in_ready}, 32'h0);
        chk(out_valid == 1'b1, "R11 valid held", {31'b0, out_valid}, 32'h1);
        p = out_px;
        repeat (3) @(negedge clk);
        #5;
        chk(out_px == p, "R11 data held in stall", out_px, p);
        ready_mode = 0;
        while (sent < 15) @(negedge clk);
        drain();

        // constrained random with random back-pressure
        ready_mode = 1;
        for (int n = 0; n < 300; n++) begin
            logic [31:0] cw, s, d, k;
            cw = $urandom & 32'h007FF7FF;
            s = $urandom; d = $urandom; k = $urandom;
            send(cw, s, d, k, model(cw, s, d, k), op_tag(cw));
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
        ready_mode = 0;
        drain();
        chk(got == sent, "R11 no pixel lost", 32'(got), 32'(sent));
        finish_run();
    end

endmodule